// File: doc/BRIEF.md
# Single-Bus Datapath with Step Sequencer

This block is a small processor core built around one shared internal bus. Eight general registers, a program counter, an instruction register, a memory address register, a memory data register, an operand holding register and an ALU result register all hang off that bus. Each register has a drive enable that places it on the bus and a load enable that captures the bus. A hardwired sequencer steps through the control strobes that move values between these registers for two jobs: fetching the next instruction word and adding one register into another.

Only one register may drive the bus in a step. An addition therefore first parks one operand in the holding register, then drives the second operand while the ALU adds the two, then drives the result back into the destination register. The fetch reuses the ALU to add the constant 4 to the PC in its first step. It writes the new PC back in the second step, which is also where the sequencer waits for the memory completion pulse.

The memory side is a single read strobe, the address held in the memory address register, a data input and a completion input. A surrounding system supplies instruction words over that port and sees the state of the core through the bus, PC, IR, flag and step outputs.

Top module: `ssb_single_bus_cpu`

## Requirements
- R1: In every step exactly one register drives the internal bus, and `busOut` shows that register's value during the step.
- R2: While `rstN` is low the step is fetch-1 with the PC at 0 and the flags at 0. Register Ri comes out of reset holding i times 32'h1111_1111.
- R3: `stepOut` encodes fetch-1, fetch-2, fetch-3, exec-1, exec-2 and exec-3 as 0 to 5. Fetch-1 raises `memRead` for one cycle and loads the PC into the memory address register, which `memAddr` shows from fetch-2 on. In fetch-3 the fetched word is on the bus and is loaded into the IR.
- R4: Each fetch advances the PC by 4, and the new value is visible from fetch-3 on.
- R5: The sequencer stays in fetch-2 while `mfc` is low and moves to fetch-3 at the edge where `mfc` is high. The memory data register captures `memRdata` at that edge. If `mfc` rises in the L-th fetch-2 cycle (L = 1 for an immediate reply), fetch-3 comes L+1 cycles after fetch-1.
- R6: Bits [31:28] of the instruction word are the opcode, and 4'hA means add. For an add, bits [5:3] select the source register and bits [2:0] select the destination. Any other opcode ends the instruction after fetch-3.
- R7: An add drives the source register onto the bus in exec-1 and the destination register in exec-2. In exec-3 it drives the 32-bit sum and writes that sum into the destination register.
- R8: The flags {N,V,C} sit in `flagsOut` bits 2, 1 and 0. N is the sum's top bit, V is two's-complement overflow and C is the carry out. They are loaded at the end of exec-2 and are visible in exec-3.
- R9: The PC increment during a fetch and instructions other than add leave the flags unchanged.
- R10: After exec-3, and after fetch-3 of a non-add instruction, the next step is fetch-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 24 | Memory address register contents |
| memRead | output | 1 | Read request strobe |
| memRdata | input | 32 | Read data from memory |
| mfc | input | 1 | Memory function completed |
| busOut | output | 32 | Value on the internal bus this step |
| pcOut | output | 32 | Program counter |
| irOut | output | 32 | Instruction register |
| flagsOut | output | 3 | Status flags {N,V,C} |
| stepOut | output | 3 | Current sequencer step |

## Verification
Fetch-3 arrives L+1 cycles after fetch-1 when the memory model answers in the L-th fetch-2 cycle. At that point the fetched word, the incremented PC and the memory address are all due. The three execute steps follow one cycle apart. The source operand, the destination operand and the sum with its new flags each appear in their own step. The bench counts falling edges from fetch-1 and compares every value at the falling edge inside the step where it is due, so each register stage is accounted for. A reference register model in the bench supplies the operands, the sums and the flags.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 8;
  localparam int REG_SEL_W = $clog2(NUM_REGS);
  localparam int FLAG_W    = 3;
  localparam int STEP_W    = 3;
  localparam int OPC_W     = 4;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'hA;
  localparam int SRC_LSB   = 3;
  localparam int DST_LSB   = 0;

  typedef enum logic [STEP_W-1:0] {
    STEP_F1 = 3'd0,
    STEP_F2 = 3'd1,
    STEP_F3 = 3'd2,
    STEP_E1 = 3'd3,
    STEP_E2 = 3'd4,
    STEP_E3 = 3'd5
  } step_e;

  typedef enum logic {
    ALU_PASS = 1'b0,
    ALU_ADD  = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic                 pcOut;
    logic                 zOut;
    logic                 mdrOut;
    logic                 regOut;
    logic                 pcIn;
    logic                 marIn;
    logic                 irIn;
    logic                 yIn;
    logic                 zIn;
    logic                 regIn;
    logic                 flagsIn;
    logic                 selY;
    logic                 read;
    logic                 wmfc;
    alu_op_e              aluOp;
    logic [REG_SEL_W-1:0] regSel;
  } ctl_t;
endpackage

// File: rtl/ssb_regfile.sv
module ssb_regfile
  import ssb_pkg::*;
#(
  parameter logic [DATA_W-1:0] INIT_STEP = 32'h1111_1111
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_SEL_W-1:0] sel,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData
);
  logic [DATA_W-1:0] regQ [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[gi] <= DATA_W'(gi) * INIT_STEP;
      else if (wrEn && (sel == REG_SEL_W'(gi)))
        regQ[gi] <= wrData;
    end
  end

  always_comb rdData = regQ[sel];
endmodule

// File: rtl/ssb_alu.sv
module ssb_alu
  import ssb_pkg::*;
#(
  parameter int INC_CONST = 4
) (
  input  alu_op_e           op,
  input  logic              selY,
  input  logic [DATA_W-1:0] yVal,
  input  logic [DATA_W-1:0] busVal,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  logic [DATA_W-1:0] aIn;
  logic [DATA_W:0]   wide;
  logic              ovf;

  always_comb begin
    aIn  = selY ? yVal : DATA_W'(INC_CONST);
    wide = {1'b0, aIn} + {1'b0, busVal};
    ovf  = (aIn[DATA_W-1] == busVal[DATA_W-1]) && (wide[DATA_W-1] != aIn[DATA_W-1]);
    if (op == ALU_ADD) begin
      result = wide[DATA_W-1:0];
      flags  = {wide[DATA_W-1], ovf, wide[DATA_W]};
    end else begin
      result = busVal;
      flags  = {busVal[DATA_W-1], 1'b0, 1'b0};
    end
  end
endmodule

// File: rtl/ssb_datapath.sv
module ssb_datapath
  import ssb_pkg::*;
#(
  parameter int                ADDR_W        = 24,
  parameter int                INC_CONST     = 4,
  parameter logic [DATA_W-1:0] REG_INIT_STEP = 32'h1111_1111
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              mfc,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] marOut,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] irOut,
  output logic [OPC_W-1:0]  fetchOpc,
  output logic [FLAG_W-1:0] flagsOut
);
  logic [DATA_W-1:0] pcQ, mdrQ, irQ, yQ, zQ;
  logic [ADDR_W-1:0] marQ;
  logic [FLAG_W-1:0] flagsQ;
  logic [DATA_W-1:0] busVal, regRd, aluRes;
  logic [FLAG_W-1:0] aluFlags;

  ssb_regfile #(.INIT_STEP(REG_INIT_STEP)) regs_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (ctl.regIn),
    .sel    (ctl.regSel),
    .wrData (busVal),
    .rdData (regRd)
  );

  ssb_alu #(.INC_CONST(INC_CONST)) alu_i (
    .op     (ctl.aluOp),
    .selY   (ctl.selY),
    .yVal   (yQ),
    .busVal (busVal),
    .result (aluRes),
    .flags  (aluFlags)
  );

  // Shared bus: each source gated by its own drive enable, then merged.
  always_comb begin
    busVal = ({DATA_W{ctl.pcOut}}  & pcQ)
           | ({DATA_W{ctl.zOut}}   & zQ)
           | ({DATA_W{ctl.mdrOut}} & mdrQ)
           | ({DATA_W{ctl.regOut}} & regRd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= '0;
      marQ   <= '0;
      mdrQ   <= '0;
      irQ    <= '0;
      yQ     <= '0;
      zQ     <= '0;
      flagsQ <= '0;
    end else begin
      if (ctl.pcIn)          pcQ    <= busVal;
      if (ctl.marIn)         marQ   <= busVal[ADDR_W-1:0];
      if (ctl.wmfc && mfc)   mdrQ   <= memRdata;
      if (ctl.irIn)          irQ    <= busVal;
      if (ctl.yIn)           yQ     <= busVal;
      if (ctl.zIn)           zQ     <= aluRes;
      if (ctl.flagsIn)       flagsQ <= aluFlags;
    end
  end

  always_comb begin
    marOut   = marQ;
    busOut   = busVal;
    pcOut    = pcQ;
    irOut    = irQ;
    fetchOpc = mdrQ[DATA_W-1 -: OPC_W];
    flagsOut = flagsQ;
  end

  assert_one_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({ctl.pcOut, ctl.zOut, ctl.mdrOut, ctl.regOut}));

  assert_pc_increment_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcOut && ctl.zIn && !ctl.selY) |=> (zQ == $past(pcQ) + DATA_W'(INC_CONST)));

  assert_sum_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.zIn && ctl.selY) |=> (zQ == $past(yQ) + $past(busVal)));

  assert_negative_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagsIn |=> (flagsQ[2] == zQ[DATA_W-1]));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flagsIn |=> $stable(flagsQ));
endmodule

// File: rtl/ssb_control.sv
module ssb_control
  import ssb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mfc,
  input  logic [OPC_W-1:0]     fetchOpc,
  input  logic [REG_SEL_W-1:0] srcSel,
  input  logic [REG_SEL_W-1:0] dstSel,
  output ctl_t                 ctl,
  output logic [STEP_W-1:0]    stepOut
);
  step_e stepQ, stepNext;

  always_comb begin
    ctl       = '0;
    ctl.aluOp = ALU_PASS;
    stepNext  = STEP_F1;
    unique case (stepQ)
      STEP_F1: begin
        ctl.pcOut = 1'b1;
        ctl.marIn = 1'b1;
        ctl.read  = 1'b1;
        ctl.aluOp = ALU_ADD;
        ctl.zIn   = 1'b1;
        stepNext  = STEP_F2;
      end
      STEP_F2: begin
        ctl.zOut  = 1'b1;
        ctl.pcIn  = 1'b1;
        ctl.wmfc  = 1'b1;
        stepNext  = mfc ? STEP_F3 : STEP_F2;
      end
      STEP_F3: begin
        ctl.mdrOut = 1'b1;
        ctl.irIn   = 1'b1;
        stepNext   = (fetchOpc == OPC_ADD) ? STEP_E1 : STEP_F1;
      end
      STEP_E1: begin
        ctl.regOut = 1'b1;
        ctl.regSel = srcSel;
        ctl.yIn    = 1'b1;
        stepNext   = STEP_E2;
      end
      STEP_E2: begin
        ctl.regOut  = 1'b1;
        ctl.regSel  = dstSel;
        ctl.selY    = 1'b1;
        ctl.aluOp   = ALU_ADD;
        ctl.zIn     = 1'b1;
        ctl.flagsIn = 1'b1;
        stepNext    = STEP_E3;
      end
      STEP_E3: begin
        ctl.zOut   = 1'b1;
        ctl.regIn  = 1'b1;
        ctl.regSel = dstSel;
        stepNext   = STEP_F1;
      end
      default: begin
        ctl.pcOut = 1'b1;
        stepNext  = STEP_F1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepQ <= STEP_F1;
    else       stepQ <= stepNext;
  end

  always_comb stepOut = stepQ;

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stepQ == STEP_F2 && !mfc) |=> (stepQ == STEP_F2));

  assert_wait_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stepQ == STEP_F2 && mfc) |=> (stepQ == STEP_F3));

  assert_non_add_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stepQ == STEP_F3 && fetchOpc != OPC_ADD) |=> (stepQ == STEP_F1));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stepQ == STEP_E3) |=> (stepQ == STEP_F1));
endmodule

// File: rtl/ssb_single_bus_cpu.sv
module ssb_single_bus_cpu
  import ssb_pkg::*;
#(
  parameter int                ADDR_W        = 24,
  parameter int                INC_CONST     = 4,
  parameter logic [DATA_W-1:0] REG_INIT_STEP = 32'h1111_1111
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              mfc,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] irOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [STEP_W-1:0] stepOut
);
  ctl_t             ctl;
  logic [OPC_W-1:0] fetchOpc;

  ssb_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .mfc      (mfc),
    .fetchOpc (fetchOpc),
    .srcSel   (irOut[SRC_LSB +: REG_SEL_W]),
    .dstSel   (irOut[DST_LSB +: REG_SEL_W]),
    .ctl      (ctl),
    .stepOut  (stepOut)
  );

  ssb_datapath #(
    .ADDR_W        (ADDR_W),
    .INC_CONST     (INC_CONST),
    .REG_INIT_STEP (REG_INIT_STEP)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .mfc      (mfc),
    .memRdata (memRdata),
    .marOut   (memAddr),
    .busOut   (busOut),
    .pcOut    (pcOut),
    .irOut    (irOut),
    .fetchOpc (fetchOpc),
    .flagsOut (flagsOut)
  );

  always_comb memRead = ctl.read;
endmodule

// File: tb/ssb_single_bus_cpu_tb_top.sv
module ssb_single_bus_cpu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENTRIES  = 8;
  localparam int WATCHDOG   = 5000;

  // Stimulus table: instruction word at address 4*k, and the fetch-2 cycle
  // (0 = first) in which the memory answers.
  localparam logic [31:0] PROG [N_ENTRIES] = '{
    32'hA000_0008,  // add R1 into R0
    32'h5123_4567,  // other opcode
    32'hA000_003F,  // add R7 into R7
    32'hA000_003E,  // add R7 into R6
    32'hA000_0000,  // add R0 into R0
    32'h7FFF_FFFF,  // other opcode
    32'hA000_001A,  // add R3 into R2
    32'hA000_0012   // add R2 into R2
  };
  localparam int LAT [N_ENTRIES] = '{1, 12, 0, 2, 3, 0, 5, 1};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] memAddr;
  logic        memRead;
  logic [31:0] memRdata = '0;
  logic        mfc = 1'b0;
  logic [31:0] busOut, pcOut, irOut;
  logic [2:0]  flagsOut, stepOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  logic [31:0] modelReg [8];
  logic [2:0]  modelFlags;

  ssb_single_bus_cpu dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .memAddr  (memAddr),
    .memRead  (memRead),
    .memRdata (memRdata),
    .mfc      (mfc),
    .busOut   (busOut),
    .pcOut    (pcOut),
    .irOut    (irOut),
    .flagsOut (flagsOut),
    .stepOut  (stepOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] progWord(input int idx);
    return (idx < N_ENTRIES) ? PROG[idx] : 32'h0000_0000;
  endfunction

  function automatic int progLat(input int idx);
    return (idx < N_ENTRIES) ? LAT[idx] : 0;
  endfunction

  // Memory responder: sees the read strobe in fetch-1, answers later.
  initial begin
    bit pending;
    int cnt;
    pending = 1'b0;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (rstN && memRead) begin
        pending = 1'b1;
        cnt = -1;
        mfc = 1'b0;
      end else if (pending) begin
        if (cnt < 0) cnt = progLat(int'(memAddr >> 2));
        if (cnt == 0) begin
          mfc = 1'b1;
          memRdata = progWord(int'(memAddr >> 2));
          pending = 1'b0;
        end else begin
          cnt--;
          mfc = 1'b0;
        end
      end else begin
        mfc = 1'b0;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired before all entries completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) modelReg[i] = 32'h1111_1111 * i;
    modelFlags = 3'b000;

    // R2: state held during reset
    repeat (3) @(negedge clk);
    check("R2 step in reset", {29'd0, stepOut}, 32'd0);
    check("R2 pc in reset", pcOut, 32'd0);
    check("R2 flags in reset", {29'd0, flagsOut}, 32'd0);
    check("R1 R3 pc drives bus in fetch-1", busOut, 32'd0);
    check("R3 read strobe in fetch-1", {31'd0, memRead}, 32'd1);

    @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < N_ENTRIES; k++) begin
      logic [31:0] instr;
      int          cycles;
      instr = PROG[k];
      check("R10 fetch-1 at instruction start", {29'd0, stepOut}, 32'd0);
      check("R1 R3 pc on bus in fetch-1", busOut, 32'(4 * k));
      cycles = 0;
      do begin
        @(negedge clk);
        cycles++;
        if (stepOut == 3'd1) begin
          check("R5 waiting step", {29'd0, stepOut}, 32'd1);
          check("R3 address shown during wait", {8'd0, memAddr}, 32'(4 * k));
        end
      end while (stepOut != 3'd2 && cycles < 100);
      check("R5 cycles fetch-1 to fetch-3", 32'(cycles), 32'(LAT[k] + 2));
      check("R4 pc after fetch", pcOut, 32'(4 * (k + 1)));
      check("R3 fetched word on bus", busOut, instr);
      check("R3 memAddr holds fetch address", {8'd0, memAddr}, 32'(4 * k));

      if (instr[31:28] == 4'hA) begin
        logic [2:0]  src, dst;
        logic [31:0] a, b, s;
        logic [32:0] wide;
        logic        v;
        src = instr[5:3];
        dst = instr[2:0];
        a = modelReg[src];
        b = modelReg[dst];
        wide = {1'b0, a} + {1'b0, b};
        s = wide[31:0];
        v = (a[31] == b[31]) && (s[31] != a[31]);
        @(negedge clk);
        check("R6 add enters exec-1", {29'd0, stepOut}, 32'd3);
        check("R3 IR holds instruction", irOut, instr);
        check("R1 R2 R7 source on bus", busOut, a);
        @(negedge clk);
        check("R7 exec-2 step", {29'd0, stepOut}, 32'd4);
        check("R1 R2 R7 destination on bus", busOut, b);
        check("R9 flags unchanged before exec-2 edge", {29'd0, flagsOut}, {29'd0, modelFlags});
        @(negedge clk);
        check("R7 exec-3 step", {29'd0, stepOut}, 32'd5);
        check("R1 R7 sum on bus", busOut, s);
        modelFlags = {s[31], v, wide[32]};
        check("R8 flags NVC", {29'd0, flagsOut}, {29'd0, modelFlags});
        modelReg[dst] = s;
        @(negedge clk);
        check("R10 return to fetch-1 after exec-3", {29'd0, stepOut}, 32'd0);
      end else begin
        check("R9 flags kept across non-add", {29'd0, flagsOut}, {29'd0, modelFlags});
        @(negedge clk);
        check("R6 R10 non-add returns to fetch-1", {29'd0, stepOut}, 32'd0);
        check("R9 flags kept after fetch increment", {29'd0, flagsOut}, {29'd0, modelFlags});
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule